// File: doc/BRIEF.md
# Register-Bus Signed Integer Divider

This block is a signed integer divider that hangs off a 16-bit register bus. Software writes a mode into a control word. It then loads a 64-bit dividend and a 64-bit divisor, each one as four 16-bit words. When the wait is over it reads back a 64-bit quotient and a 64-bit remainder, also as four words each. Every write to the control word or to an operand word starts the calculation again. A busy bit in the control word stays set for a fixed number of cycles that depends on the mode. When that count runs out, the results are latched and the busy bit drops.

The latency is meant to match a timing contract and not the speed of the datapath. Software can therefore poll the busy bit, or it can wait for a known number of cycles. Reads have no side effects.

Top module: `int_div_regs`

## Requirements
- R1: After reset, the control word reads 0x4000: busy is 0, the zero-divisor flag is 1 and the mode is 0. Every operand word and every result word reads 0.
- R2: Word address map. Address 0 is control. Addresses 4..7 hold the dividend and 8..11 the divisor. Addresses 12..15 hold the quotient and 16..19 the remainder. In each group the lowest address holds bits 15:0. Control bits 1:0 hold the mode, bit 14 is the zero-divisor flag and bit 15 is busy. All other control bits read 0.
- R3: Busy stays set for exactly 68 cycles in mode 0 and for exactly 36 cycles in modes 1, 2 and 3. The count starts at the write that began the calculation.
- R4: A write to the control word stores the mode, sets busy and loads the full latency for the new mode.
- R5: A write to any dividend or divisor word sets busy and reloads the full latency, even if a calculation is already in flight. A completion that was pending is dropped.
- R6: The quotient and remainder words change only at the cycle where busy clears. Until then they keep their previous values.
- R7: Mode 0 divides bits 31:0 of the dividend by bits 31:0 of the divisor, both sign-extended. Mode 1 divides the 64-bit dividend by bits 31:0 of the divisor, sign-extended. Modes 2 and 3 divide 64 bits by 64 bits. Results are always 64 bits wide.
- R8: Division is signed two's complement. The quotient is truncated toward zero and the remainder takes the sign of the dividend. The most negative 64-bit value divided by -1 gives that same value with remainder 0.
- R9: Control bit 14 reads 1 exactly when all 64 bits of the divisor are zero.
- R10: When the effective divisor is zero, the quotient is -1 for a non-negative effective dividend and +1 for a negative one. The remainder equals the effective dividend.
- R11: Reads change no state. Writes to result words or to unmapped addresses change nothing and do not start a calculation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Word address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |

## Verification
The division is tried with dividend and divisor in all four sign combinations. This separates truncation toward zero from floor division, and shows the sign rule for the remainder. Some patterns place non-zero bits above bit 31 that a narrow mode must ignore. Others give a divisor whose low half is zero but whose upper half is not. Together these separate the three operand widths and show that mode 3 acts like mode 2. Divisors that are zero are tried with positive and with negative dividends, and the most-negative overflow case is tried at both 32 and 64 bits. The busy duration is measured per mode and again after a restart in mid-flight, which separates a full reload from a counter that keeps running.

// File: rtl/int_div_pkg.sv
package int_div_pkg;
  localparam int DIV_W  = 64;
  localparam int HALF_W = DIV_W / 2;

  typedef struct packed {
    logic [DIV_W-1:0] quo;
    logic [DIV_W-1:0] rem;
  } div_res_t;

  // Mode-dependent operand widening, then signed division via magnitudes.
  function automatic div_res_t div_compute(input logic [1:0] mode,
                                           input logic [DIV_W-1:0] dvd,
                                           input logic [DIV_W-1:0] dvs);
    div_res_t res;
    logic [DIV_W-1:0] en, ed, an, ad, qm, rm;
    logic sn, sd;
    en = (mode == 2'd0) ? {{HALF_W{dvd[HALF_W-1]}}, dvd[HALF_W-1:0]} : dvd;
    ed = mode[1] ? dvs : {{HALF_W{dvs[HALF_W-1]}}, dvs[HALF_W-1:0]};
    sn = en[DIV_W-1];
    sd = ed[DIV_W-1];
    if (ed == '0) begin
      res.quo = sn ? {{(DIV_W-1){1'b0}}, 1'b1} : {DIV_W{1'b1}};
      res.rem = en;
    end else begin
      an = sn ? -en : en;
      ad = sd ? -ed : ed;
      qm = an / ad;
      rm = an % ad;
      res.quo = (sn ^ sd) ? -qm : qm;
      res.rem = sn ? -rm : rm;
    end
    return res;
  endfunction
endpackage

// File: rtl/div_latency_timer.sv
module div_latency_timer #(
  parameter int LAT_FULL = 68,
  parameter int LAT_FAST = 36
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] start_mode,
  output logic       busy,
  output logic       done
);
  localparam int CNT_W = $clog2(LAT_FULL + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lat_sel;

  assign lat_sel = (start_mode == 2'd0) ? CNT_W'(LAT_FULL) : CNT_W'(LAT_FAST);
  // A restart in the final cycle cancels the pending completion.
  assign done = busy && (cnt_q == CNT_W'(1)) && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= lat_sel;
    end else if (busy) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) busy <= 1'b0;
    end
  end

  // R4
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R3
  done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R3
  count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q != '0 && cnt_q <= CNT_W'(LAT_FULL)));
endmodule

// File: rtl/div_result_regs.sv
module div_result_regs
  import int_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [1:0]       mode,
  input  logic [DIV_W-1:0] dvd,
  input  logic [DIV_W-1:0] dvs,
  output logic [DIV_W-1:0] quo_q,
  output logic [DIV_W-1:0] rem_q
);
  div_res_t res;
  assign res = div_compute(mode, dvd, dvs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
    end else if (commit) begin
      quo_q <= res.quo;
      rem_q <= res.rem;
    end
  end

  // R6
  results_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(quo_q) && $stable(rem_q)));
endmodule

// File: rtl/int_div_regs.sv
module int_div_regs
  import int_div_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int ADDR_W   = 5,
  parameter int LAT_FULL = 68,
  parameter int LAT_FAST = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata
);
  localparam int NWORDS   = DIV_W / WORD_W;
  localparam int CTRL_A   = 0;
  localparam int DVD_BASE = 4;
  localparam int DVS_BASE = DVD_BASE + NWORDS;
  localparam int QUO_BASE = DVS_BASE + NWORDS;
  localparam int REM_BASE = QUO_BASE + NWORDS;

  logic [1:0]       mode_q;
  logic [DIV_W-1:0] dvd_q, dvs_q, quo_q, rem_q;
  logic             busy, done, start, wr_ctrl, wr_opnd, zero_dvs;
  logic [1:0]       start_mode;

  assign wr_ctrl  = bus_wr && (int'(bus_addr) == CTRL_A);
  assign wr_opnd  = bus_wr && (int'(bus_addr) >= DVD_BASE) && (int'(bus_addr) < QUO_BASE);
  assign start    = wr_ctrl || wr_opnd;
  assign start_mode = wr_ctrl ? bus_wdata[1:0] : mode_q;
  assign zero_dvs = (dvs_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dvd_q  <= '0;
      dvs_q  <= '0;
    end else if (bus_wr) begin
      if (wr_ctrl) mode_q <= bus_wdata[1:0];
      for (int i = 0; i < NWORDS; i++) begin
        if (int'(bus_addr) == DVD_BASE + i) dvd_q[i*WORD_W +: WORD_W] <= bus_wdata;
        if (int'(bus_addr) == DVS_BASE + i) dvs_q[i*WORD_W +: WORD_W] <= bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (int'(bus_addr) == CTRL_A)
      bus_rdata = {busy, zero_dvs, {(WORD_W-4){1'b0}}, mode_q};
    for (int i = 0; i < NWORDS; i++) begin
      if (int'(bus_addr) == DVD_BASE + i) bus_rdata = dvd_q[i*WORD_W +: WORD_W];
      if (int'(bus_addr) == DVS_BASE + i) bus_rdata = dvs_q[i*WORD_W +: WORD_W];
      if (int'(bus_addr) == QUO_BASE + i) bus_rdata = quo_q[i*WORD_W +: WORD_W];
      if (int'(bus_addr) == REM_BASE + i) bus_rdata = rem_q[i*WORD_W +: WORD_W];
    end
  end

  div_latency_timer #(.LAT_FULL(LAT_FULL), .LAT_FAST(LAT_FAST)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .start_mode(start_mode),
    .busy(busy), .done(done)
  );

  div_result_regs u_results (
    .clk(clk), .rst_n(rst_n), .commit(done), .mode(mode_q),
    .dvd(dvd_q), .dvs(dvs_q), .quo_q(quo_q), .rem_q(rem_q)
  );

  // R11
  idle_bus_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(dvd_q) && $stable(dvs_q) && $stable(mode_q)));
  // R5
  operand_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_opnd |=> (busy && $stable(quo_q)));
  // R6
  commit_only_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(quo_q) || $changed(rem_q)) |-> $past(done));
endmodule

// File: tb/test_int_div_regs.sv
module test_int_div_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  int_div_regs i_int_div_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  localparam int NV = 11;
  localparam logic [1:0] VM [NV] = '{2'd2, 2'd2, 2'd2, 2'd2, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 2'd2, 2'd0};
  localparam logic [63:0] VN [NV] = '{
    64'd100, -64'd100, 64'd100, -64'd100,
    64'h1234_5678_0000_0064, 64'h0000_0000_FFFF_FF9C,
    64'h0000_0001_0000_0000, 64'h0000_0100_0000_0000, 64'h0000_0100_0000_0000,
    64'h8000_0000_0000_0000, 64'h0000_0000_8000_0000};
  localparam logic [63:0] VD [NV] = '{
    64'd7, 64'd7, -64'd7, -64'd7,
    64'hFFFF_0000_0000_0007, 64'd7,
    64'h1234_5678_0000_0010, 64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000,
    {64{1'b1}}, {64{1'b1}}};
  localparam logic [63:0] VQ [NV] = '{
    64'd14, -64'd14, -64'd14, 64'd14,
    64'd14, -64'd14,
    64'h0000_0000_1000_0000, 64'h100, 64'h100,
    64'h8000_0000_0000_0000, 64'h0000_0000_8000_0000};
  localparam logic [63:0] VR [NV] = '{
    64'd2, -64'd2, 64'd2, -64'd2,
    64'd2, -64'd2,
    64'd0, 64'd0, 64'd0, 64'd0, 64'd0};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic rd64(input logic [4:0] base, output logic [63:0] v);
    logic [15:0] w;
    for (int i = 0; i < 4; i++) begin
      rd(base + 5'(i), w);
      v[i*16 +: 16] = w;
    end
  endtask

  // Counts negedges with busy set, starting right after the starting write.
  task automatic busy_len(output int n);
    logic [15:0] c;
    n = 0;
    for (int k = 0; k < 2000; k++) begin
      rd(5'd0, c);
      if (!c[15]) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic load(input logic [1:0] m, input logic [63:0] n, input logic [63:0] d);
    int len;
    wr(5'd0, {14'd0, m});
    for (int i = 0; i < 4; i++) wr(5'd4 + 5'(i), n[i*16 +: 16]);
    for (int i = 0; i < 4; i++) wr(5'd8 + 5'(i), d[i*16 +: 16]);
    busy_len(len);
  endtask

  initial begin
    #1_600_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] w;
    logic [63:0] q, r, v;
    int len;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(5'd0, w);  check("R1 ctrl", 64'(w), 64'h4000);
    rd64(5'd4, v);  check("R1 dividend", v, 64'd0);
    rd64(5'd12, v); check("R1 quotient", v, 64'd0);
    rd64(5'd16, v); check("R1 remainder", v, 64'd0);

    // R3 R4 latency per mode
    wr(5'd0, 16'h0000); busy_len(len); check("R3 R4 mode0 latency", 64'(len), 64'd68);
    wr(5'd0, 16'h0001); busy_len(len); check("R3 R4 mode1 latency", 64'(len), 64'd36);
    wr(5'd0, 16'hFFFF); busy_len(len); check("R3 mode3 latency", 64'(len), 64'd36);
    rd(5'd0, w); check("R2 R9 ctrl readback", 64'(w), 64'h4003);

    // R7 R8 vector table
    for (int t = 0; t < NV; t++) begin
      load(VM[t], VN[t], VD[t]);
      rd64(5'd12, q); rd64(5'd16, r);
      check($sformatf("R7 R8 vec%0d quotient", t), q, VQ[t]);
      check($sformatf("R7 R8 vec%0d remainder", t), r, VR[t]);
    end

    // R9 R10 zero divisor
    load(2'd2, 64'd5, 64'd0);
    rd(5'd0, w); check("R9 flag set", 64'(w[14]), 64'd1);
    rd64(5'd12, q); rd64(5'd16, r);
    check("R10 pos quotient", q, {64{1'b1}}); check("R10 pos remainder", r, 64'd5);
    load(2'd2, -64'd5, 64'd0);
    rd64(5'd12, q); rd64(5'd16, r);
    check("R10 neg quotient", q, 64'd1); check("R10 neg remainder", r, -64'd5);
    load(2'd0, 64'd9, 64'h0000_0001_0000_0000);
    rd(5'd0, w); check("R9 flag clear", 64'(w[14]), 64'd0);
    rd64(5'd12, q); check("R10 low-half zero quotient", q, {64{1'b1}});

    // R6 results hold during busy; R5 restart from full latency
    load(2'd1, 64'd100, 64'd7);
    wr(5'd4, 16'd200);
    rd64(5'd12, q); check("R6 hold during busy", q, 64'd14);
    repeat (20) @(negedge clk);
    rd64(5'd12, q); check("R6 hold mid flight", q, 64'd14);
    wr(5'd9, 16'd0);
    busy_len(len); check("R5 restart latency", 64'(len), 64'd36);
    rd64(5'd12, q); rd64(5'd16, r);
    check("R5 R6 new quotient", q, 64'd28); check("R5 R6 new remainder", r, 64'd4);

    // R11 ignored writes and side-effect-free reads
    wr(5'd12, 16'hBEEF);
    rd(5'd0, w); check("R11 result write no busy", 64'(w[15]), 64'd0);
    rd64(5'd12, q); check("R11 result write ignored", q, 64'd28);
    wr(5'd25, 16'h1234);
    rd(5'd0, w); check("R11 unmapped write no busy", 64'(w), 64'h0001);
    rd64(5'd4, v); rd64(5'd4, v); check("R11 R2 dividend readback", v, 64'd200);
    rd64(5'd16, r); check("R11 remainder stable", r, 64'd4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule